// File: doc/BRIEF.md
# Chain Binding Engine

This block binds two chains of fixed-width items. A chain holds up to `MAX_ITEMS` items. Each item is `ITEM_ELEMS` elements of `ELEM_W` bits. The number of valid items in a chain is its rank. The engine pairs every item of operand A with every item of operand B. It combines each pair element by element, using addition or subtraction modulo 2^`ELEM_W`, and writes the pair results into the result chain in row-major order. The result rank is the product of the two operand ranks.

A request captures both operands, their ranks and the mode. One control stage then checks whether the rank product fits in a chain. After that, one item pair passes through the single item-wide adder/subtractor on each clock cycle. The engine pulses done at the end. Results, rank, the overflow flag and the equality flag stay unchanged until the next accepted request.

Item k of a chain sits at bits `[k*ITEM_W +: ITEM_W]`, where `ITEM_W = ELEM_W*ITEM_ELEMS`. Element e of an item sits at bits `[e*ELEM_W +: ELEM_W]`.

Top module: `chain_bind_engine`

## Requirements
- R1: In add mode (`sub_mode`=0), each result element is (a + b) mod 2^ELEM_W. A carry out of one element never reaches its neighbour.
- R2: In subtract mode (`sub_mode`=1), each result element is (a - b) mod 2^ELEM_W, with A the minuend and B the subtrahend. This equals a plus the two's complement of b.
- R3: The result for A item i and B item j goes to output slot i*rank_b + j. Every slot at or above the rank product reads as zero.
- R4: After done, `res_rank` equals rank_a*rank_b. When one operand has rank 1, the result keeps the other operand's length.
- R5: If rank_a*rank_b exceeds MAX_ITEMS, then at done `ovf` is 1, `res_rank` is 0 and `res_chain` is all zero. Otherwise `ovf` is 0 at done.
- R6: `eq` is 1 after an operation exactly when item 0 of A equals item 0 of B. It is 0 when the operation overflowed or had a rank product of 0. It holds its value until the next accepted request.
- R7: `done` is a single-cycle pulse. It is seen P+1 clock edges after the edge that accepts the request when P=rank_a*rank_b lies between 1 and MAX_ITEMS. It is seen after 1 edge when P is 0 or overflows.
- R8: A request raised while an operation is in progress is ignored. The running operation finishes with its own operands, and no second done follows.
- R9: Binding with a rank-1 all-zero item in add mode returns the other operand unchanged (identity item).
- R10: After reset, `res_chain`, `res_rank`, `eq`, `done` and `ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a binding; sampled while idle |
| sub_mode | input | 1 | 0 = modular add, 1 = modular subtract |
| a_chain | input | MAX_ITEMS*ITEM_W | Operand A items |
| a_rank | input | RW | Item count of A |
| b_chain | input | MAX_ITEMS*ITEM_W | Operand B items |
| b_rank | input | RW | Item count of B |
| res_chain | output | MAX_ITEMS*ITEM_W | Bound result chain |
| res_rank | output | RW | Item count of result |
| eq | output | 1 | First item pair was equal |
| done | output | 1 | Operation finished (one cycle) |
| ovf | output | 1 | Rank product exceeded MAX_ITEMS |

## Verification
The bench sweeps every rank pair from 0 to MAX_ITEMS in both modes. It uses element patterns that often wrap, so a carry leaking across an element boundary or a wrongly inverted subtrahend gives a wrong value. Rank pairs that have the same product but swapped ranks, such as 1x4 against 4x1 and 2x2, show whether slot placement is really row-major and whether the slots above the product stay zero. Further runs cover the zero identity item, a forced equal first pair against an unequal one, and requests raised while busy.

// File: rtl/chain_bind_pkg.sv
package chain_bind_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } bind_state_t;
endpackage

// File: rtl/chain_bind_alu.sv
// Item-wide modular adder/subtractor: one lane per element, carries dropped.
module chain_bind_alu #(
  parameter int ELEM_W     = 4,
  parameter int ITEM_ELEMS = 4,
  localparam int ITEM_W    = ELEM_W * ITEM_ELEMS
) (
  input  logic [ITEM_W-1:0] op_a,
  input  logic [ITEM_W-1:0] op_b,
  input  logic              sub,
  output logic [ITEM_W-1:0] res,
  output logic              eq
);
  genvar e;
  generate
    for (e = 0; e < ITEM_ELEMS; e++) begin : g_lane
      logic [ELEM_W-1:0] a_e, b_e, b_in;
      assign a_e  = op_a[e*ELEM_W +: ELEM_W];
      assign b_e  = op_b[e*ELEM_W +: ELEM_W];
      assign b_in = sub ? ('0 - b_e) : b_e;
      assign res[e*ELEM_W +: ELEM_W] = a_e + b_in;
    end
  endgenerate

  assign eq = (op_a == op_b);
endmodule

// File: rtl/chain_bind_ctrl.sv
// Sequencer: rank check, row-major pair walk, done/overflow/rank registers.
module chain_bind_ctrl
  import chain_bind_pkg::*;
#(
  parameter int MAX_ITEMS = 4,
  localparam int RW = $clog2(MAX_ITEMS + 1),
  localparam int IW = (MAX_ITEMS > 1) ? $clog2(MAX_ITEMS) : 1,
  localparam int PW = 2 * RW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [RW-1:0] rank_a,
  input  logic [RW-1:0] rank_b,
  output logic          cap,
  output logic          setup,
  output logic          wr_en,
  output logic          first,
  output logic [IW-1:0] idx_a,
  output logic [IW-1:0] idx_b,
  output logic [IW-1:0] slot,
  output logic          busy,
  output logic          done,
  output logic          ovf,
  output logic [RW-1:0] res_rank
);
  localparam logic [PW-1:0] MAX_P = PW'(MAX_ITEMS);

  bind_state_t state;
  logic [PW-1:0] prod;
  logic          too_big, last_b, last_a;

  assign prod    = PW'(rank_a) * PW'(rank_b);
  assign too_big = prod > MAX_P;
  assign last_b  = (RW'(idx_b) + RW'(1)) == rank_b;
  assign last_a  = (RW'(idx_a) + RW'(1)) == rank_a;

  assign cap   = (state == ST_IDLE) && req;
  assign setup = (state == ST_SETUP);
  assign wr_en = (state == ST_RUN);
  assign first = wr_en && (slot == '0);
  assign busy  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx_a    <= '0;
      idx_b    <= '0;
      slot     <= '0;
      done     <= 1'b0;
      ovf      <= 1'b0;
      res_rank <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            ovf   <= 1'b0;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          idx_a <= '0;
          idx_b <= '0;
          slot  <= '0;
          ovf   <= too_big;
          res_rank <= too_big ? '0 : RW'(prod);
          if (too_big || prod == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          slot <= slot + IW'(1);
          if (last_b) begin
            idx_b <= '0;
            if (last_a) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              idx_a <= idx_a + IW'(1);
            end
          end else begin
            idx_b <= idx_b + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_bind_engine.sv
// Top: operand capture, ALU, result chain storage, equality flag.
module chain_bind_engine #(
  parameter int ELEM_W     = 4,
  parameter int ITEM_ELEMS = 4,
  parameter int MAX_ITEMS  = 4,
  localparam int ITEM_W    = ELEM_W * ITEM_ELEMS,
  localparam int CW        = MAX_ITEMS * ITEM_W,
  localparam int RW        = $clog2(MAX_ITEMS + 1),
  localparam int IW        = (MAX_ITEMS > 1) ? $clog2(MAX_ITEMS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          sub_mode,
  input  logic [CW-1:0] a_chain,
  input  logic [RW-1:0] a_rank,
  input  logic [CW-1:0] b_chain,
  input  logic [RW-1:0] b_rank,
  output logic [CW-1:0] res_chain,
  output logic [RW-1:0] res_rank,
  output logic          eq,
  output logic          done,
  output logic          ovf
);
  logic [CW-1:0]     a_q, b_q;
  logic [RW-1:0]     ra_q, rb_q;
  logic              sub_q;
  logic              cap, setup, wr_en, first, busy;
  logic [IW-1:0]     idx_a, idx_b, slot;
  logic [ITEM_W-1:0] item_a, item_b, item_r;
  logic              alu_eq;

  chain_bind_ctrl #(.MAX_ITEMS(MAX_ITEMS)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .rank_a(ra_q), .rank_b(rb_q),
    .cap(cap), .setup(setup), .wr_en(wr_en), .first(first),
    .idx_a(idx_a), .idx_b(idx_b), .slot(slot), .busy(busy),
    .done(done), .ovf(ovf), .res_rank(res_rank)
  );

  assign item_a = a_q[idx_a*ITEM_W +: ITEM_W];
  assign item_b = b_q[idx_b*ITEM_W +: ITEM_W];

  chain_bind_alu #(.ELEM_W(ELEM_W), .ITEM_ELEMS(ITEM_ELEMS)) u_alu (
    .op_a(item_a), .op_b(item_b), .sub(sub_q), .res(item_r), .eq(alu_eq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      sub_q <= 1'b0;
    end else if (cap) begin
      a_q   <= a_chain;
      b_q   <= b_chain;
      ra_q  <= a_rank;
      rb_q  <= b_rank;
      sub_q <= sub_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_chain <= '0;
      eq        <= 1'b0;
    end else begin
      if (cap) eq <= 1'b0;
      if (first) eq <= alu_eq;
      if (setup) res_chain <= '0;
      else if (wr_en) res_chain[slot*ITEM_W +: ITEM_W] <= item_r;
    end
  end
endmodule

// File: rtl/chain_bind_checker.sv
module chain_bind_checker #(
  parameter int MAX_ITEMS = 4,
  localparam int RW = $clog2(MAX_ITEMS + 1),
  localparam int PW = 2 * RW
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          busy,
  input logic [RW-1:0] a_rank,
  input logic [RW-1:0] b_rank,
  input logic [RW-1:0] ra_q,
  input logic [RW-1:0] rb_q,
  input logic [RW-1:0] res_rank,
  input logic          done,
  input logic          ovf,
  input logic          eq
);
  logic [PW-1:0] exp_prod;
  always_ff @(posedge clk) begin
    if (rst) exp_prod <= '0;
    else if (req && !busy) exp_prod <= PW'(a_rank) * PW'(b_rank);
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_ovf_rank_R5: assert property (@(posedge clk) disable iff (rst)
    ovf |-> res_rank == '0);
  assert_ovf_cond_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (ovf == (exp_prod > PW'(MAX_ITEMS))));
  assert_rank_product_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf) |-> (PW'(res_rank) == exp_prod));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(ra_q) && $stable(rb_q)));
  assert_eq_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req) |=> $stable(eq));
  assert_ovf_noeq_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |-> !eq);
endmodule

bind chain_bind_engine chain_bind_checker #(.MAX_ITEMS(MAX_ITEMS)) u_chk (
  .clk(clk), .rst(rst), .req(req), .busy(busy), .a_rank(a_rank),
  .b_rank(b_rank), .ra_q(ra_q), .rb_q(rb_q), .res_rank(res_rank),
  .done(done), .ovf(ovf), .eq(eq)
);

// File: tb/chain_bind_engine_test.sv
module chain_bind_engine_test;
  localparam int EW = 4, NE = 4, MI = 4;
  localparam int IWD = EW * NE, CW = MI * IWD, RW = $clog2(MI + 1);

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, sub_mode = 1'b0;
  logic [CW-1:0] a_chain = '0, b_chain = '0, res_chain;
  logic [RW-1:0] a_rank = '0, b_rank = '0, res_rank;
  logic eq, done, ovf;
  int tests = 0, fails = 0;

  chain_bind_engine #(.ELEM_W(EW), .ITEM_ELEMS(NE), .MAX_ITEMS(MI)) uut (
    .clk(clk), .rst(rst), .req(req), .sub_mode(sub_mode),
    .a_chain(a_chain), .a_rank(a_rank), .b_chain(b_chain), .b_rank(b_rank),
    .res_chain(res_chain), .res_rank(res_rank), .eq(eq), .done(done), .ovf(ovf)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] pattern(int seed);
    logic [CW-1:0] v;
    for (int k = 0; k < MI * NE; k++)
      v[k*EW +: EW] = EW'((seed * 13 + k * 7 + k * k * 3 + 11) % 16);
    return v;
  endfunction

  function automatic logic [CW-1:0] expect_chain(logic [CW-1:0] a, logic [CW-1:0] b,
                                                 int ra, int rb, logic sub);
    logic [CW-1:0] r = '0;
    if (ra * rb > MI) return r;
    for (int i = 0; i < ra; i++)
      for (int j = 0; j < rb; j++)
        for (int e = 0; e < NE; e++) begin
          int av = int'(a[(i*NE+e)*EW +: EW]);
          int bv = int'(b[(j*NE+e)*EW +: EW]);
          int s  = sub ? (av - bv + 16) % 16 : (av + bv) % 16;
          r[((i*rb+j)*NE+e)*EW +: EW] = EW'(s);
        end
    return r;
  endfunction

  // Issue one request, measure edges to done, check all results.
  task automatic run_op(logic [CW-1:0] a, int ra, logic [CW-1:0] b, int rb,
                        logic sub, string tag, bit busy_poke);
    int lat = 0, p = ra * rb;
    logic exp_ovf = p > MI;
    int exp_rank = exp_ovf ? 0 : p;
    int exp_lat = (exp_ovf || p == 0) ? 1 : p + 1;
    logic exp_eq = (!exp_ovf && p > 0) && (a[IWD-1:0] == b[IWD-1:0]);
    @(negedge clk);
    a_chain = a; b_chain = b; a_rank = RW'(ra); b_rank = RW'(rb); sub_mode = sub;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (busy_poke) begin
      a_chain = ~a; a_rank = RW'(1); b_rank = RW'(1); req = 1'b1;
    end
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    check({tag, " R7 latency"}, CW'(lat), CW'(exp_lat));
    check({tag, " R1/R2/R3 chain"}, res_chain, expect_chain(a, b, ra, rb, sub));
    check({tag, " R4 rank"}, CW'(res_rank), CW'(exp_rank));
    check({tag, " R5 ovf"}, CW'(ovf), CW'(exp_ovf));
    check({tag, " R6 eq"}, CW'(eq), CW'(exp_eq));
    @(negedge clk);
    check({tag, " R7 pulse"}, CW'(done), CW'(0));
    check({tag, " R6 eq hold"}, CW'(eq), CW'(exp_eq));
    if (busy_poke) check({tag, " R8 no redo"}, res_chain, expect_chain(a, b, ra, rb, sub));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset chain", res_chain, '0);
    check("R10 reset flags", CW'({res_rank, eq, done, ovf}), '0);

    // Sweep of rank pairs and both modes
    for (int m = 0; m < 2; m++)
      for (int ra = 0; ra <= MI; ra++)
        for (int rb = 0; rb <= MI; rb++)
          run_op(pattern(ra * 5 + rb + m), ra, pattern(ra + rb * 9 + 40 + m), rb,
                 logic'(m), "sweep", 1'b0);

    // Wrap-heavy: all-ones items (carry isolation, R1) and subtrahend larger (R2)
    run_op({CW{1'b1}}, 2, {CW{1'b1}}, 2, 1'b0, "R1 wrap", 1'b0);
    run_op('0, 1, {CW{1'b1}}, 4, 1'b1, "R2 negate", 1'b0);

    // R9 zero identity item, both sides
    run_op(pattern(77), 4, '0, 1, 1'b0, "R9 idB", 1'b0);
    check("R9 identity value", res_chain, pattern(77));
    run_op('0, 1, pattern(78), 3, 1'b0, "R9 idA", 1'b0);

    // R6 forced equal first pair, then unequal
    run_op(pattern(5), 2, pattern(5), 2, 1'b1, "R6 equal", 1'b0);
    run_op(pattern(5), 2, pattern(6), 2, 1'b0, "R6 unequal", 1'b0);

    // R8 request while busy is ignored
    run_op(pattern(90), 4, pattern(91), 1, 1'b0, "R8 busy", 1'b1);
    run_op(pattern(92), 2, pattern(93), 2, 1'b1, "R8 busy2", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule